// File: doc/BRIEF.md
# Cascaded Two-Digit Modulo-24 Counter

This block is a synchronous 8-bit counter made of two 4-bit stages that share one clock. The low stage steps from 3 up to 8 and then reloads 3; each reload also moves the high stage on by one. The high stage runs 0 to 3 and is cleared when the state reaches hex 38. The result is a non-contiguous sequence of 24 states: 03..08, 13..18, 23..28, 33..38, then back to 03.

The count enable gates every change of state, including a pending reload or clear. A synchronous reset returns the counter to 03. A terminal flag marks the last state of the cycle, so the block can be cascaded further or used as a frame or phase divider. The stage width, the low start value, the high-stage decode mask and the timing of the terminal flag are parameters. Their defaults give the 24-state sequence.

Top module: `cnt24_cascade`

## Requirements
- R1: With `rst` high at a clock edge, `state` becomes 0x03 and `at_term` becomes 0 after that edge.
- R2: With `cnt_en` low and `rst` low, `state` does not change at the edge. This also holds in states 0x08 and 0x38, where a reload or clear is pending.
- R3: With `cnt_en` high and `state[3]` equal to 0, the low nibble `state[3:0]` goes up by one and the high nibble `state[7:4]` keeps its value.
- R4: With `cnt_en` high and `state[3]` equal to 1 (low nibble 8), the low nibble loads 3 at the edge.
- R5: On the same edge as the R4 reload, the high nibble goes up by one, unless the clear of R6 applies.
- R6: With `cnt_en` high and `state[5]`, `state[4]` and `state[3]` all equal to 1 (state 0x38), the high nibble clears instead of counting, so the next state is 0x03.
- R7: With the enable held high, the counter passes through exactly 24 distinct states and returns to 0x03 after 24 edges.
- R8: `at_term` is 1 exactly while `state` equals 0x38.
- R9: After reset, the low nibble always lies in 3..8 and the high nibble in 0..3.
- R10: Reset takes priority over the count enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, forces 0x03 |
| cnt_en | input | 1 | Count enable; when low the state holds |
| state | output | 8 | Counter state, high digit in bits 7:4, low digit in bits 3:0 |
| at_term | output | 1 | High while the state is 0x38 |

## Verification
Two functions can fall in the same cycle. The low-stage reload and the high-stage carry share an edge, and at 0x38 the high-stage clear competes with that carry. Reset can also coincide with an active enable. The bench provokes these by running the enable high through all four digit wraps, by parking the enable low while a reload or clear is pending, and by asserting reset while counting. Every cycle it compares the state and the flag against an index-based model that knows nothing of the stage structure.

// File: rtl/cnt24_pkg.sv
package cnt24_pkg;
   // Operation one counter stage performs at the next edge; CLEAR outranks LOAD
   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_INC   = 2'd1,
      OP_LOAD  = 2'd2,
      OP_CLEAR = 2'd3
   } stage_op_e;
endpackage

// File: rtl/cnt24_stage.sv
module cnt24_stage
   import cnt24_pkg::*;
#(
   parameter int NIB_W    = 4,
   parameter int LOAD_VAL = 3,
   parameter int RST_VAL  = 0
)(
   input  logic             clk,
   input  logic             rst,
   input  stage_op_e        op,
   output logic [NIB_W-1:0] q
);
   localparam logic [NIB_W-1:0] LOAD_V = NIB_W'(LOAD_VAL);
   localparam logic [NIB_W-1:0] RST_V  = NIB_W'(RST_VAL);
   localparam logic [NIB_W-1:0] ONE    = NIB_W'(1);

   generate
      if (NIB_W < 1) begin : g_bad_w
         $error("cnt24_stage: NIB_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         q <= RST_V;
      end else begin
         unique case (op)
            OP_CLEAR: q <= '0;
            OP_LOAD:  q <= LOAD_V;
            OP_INC:   q <= q + ONE;
            default:  q <= q;
         endcase
      end
   end
endmodule

// File: rtl/cnt24_ctrl.sv
module cnt24_ctrl
   import cnt24_pkg::*;
#(
   parameter int NIB_W     = 4,
   parameter int HIGH_MASK = 3
)(
   input  logic             en,
   input  logic [NIB_W-1:0] lo,
   input  logic [NIB_W-1:0] hi,
   output stage_op_e        lo_op,
   output stage_op_e        hi_op
);
   localparam int               TRIG   = NIB_W - 1;
   localparam logic [NIB_W-1:0] MASK_V = NIB_W'(HIGH_MASK);

   logic lo_wrap;
   logic hi_last;

   // Low stage leaves its range when its top bit sets; high stage clears on masked all-ones
   assign lo_wrap = lo[TRIG];
   assign hi_last = ((hi & MASK_V) == MASK_V);

   always_comb begin
      lo_op = OP_HOLD;
      hi_op = OP_HOLD;
      if (en) begin
         if (lo_wrap) begin
            lo_op = OP_LOAD;
            hi_op = hi_last ? OP_CLEAR : OP_INC;
         end else begin
            lo_op = OP_INC;
         end
      end
   end
endmodule

// File: rtl/cnt24_term.sv
module cnt24_term #(
   parameter int                OUT_W      = 8,
   parameter logic [OUT_W-1:0]  TERM_STATE = 8'h38,
   parameter logic [OUT_W-1:0]  PRE_TERM   = 8'h37,
   parameter bit                REGISTERED = 1'b1
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [OUT_W-1:0] state,
   output logic             at_term
);
   generate
      if (REGISTERED) begin : g_reg
         // Flag predicted one step ahead so it needs no wide compare after the state flops
         always_ff @(posedge clk) begin
            if (rst)     at_term <= 1'b0;
            else if (en) at_term <= (state == PRE_TERM);
         end

         AST_TERM_TRACK: assert property (@(posedge clk) disable iff (rst)
            at_term == (state == TERM_STATE)); // R8
      end else begin : g_comb
         logic unused_ok;
         assign unused_ok = clk ^ rst ^ en;
         assign at_term   = (state == TERM_STATE);
      end
   endgenerate
endmodule

// File: rtl/cnt24_cascade.sv
module cnt24_cascade
   import cnt24_pkg::*;
#(
   parameter int NIB_W     = 4,
   parameter int LOW_INIT  = 3,
   parameter int HIGH_MASK = 3,
   parameter bit TERM_REG  = 1'b1
)(
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 cnt_en,
   output logic [2*NIB_W-1:0]   state,
   output logic                 at_term
);
   localparam int OUT_W   = 2 * NIB_W;
   localparam int TRIG    = NIB_W - 1;
   localparam int MODULUS = ((2 ** (NIB_W - 1)) - LOW_INIT + 1) * (HIGH_MASK + 1);

   localparam logic [NIB_W-1:0] ONE       = NIB_W'(1);
   localparam logic [NIB_W-1:0] LO_INIT_V = NIB_W'(LOW_INIT);
   localparam logic [NIB_W-1:0] LO_TOP    = {1'b1, {(NIB_W-1){1'b0}}};
   localparam logic [NIB_W-1:0] LO_PRE    = LO_TOP - ONE;
   localparam logic [NIB_W-1:0] HI_MASK_V = NIB_W'(HIGH_MASK);
   localparam logic [OUT_W-1:0] RST_STATE  = {{NIB_W{1'b0}}, LO_INIT_V};
   localparam logic [OUT_W-1:0] TERM_STATE = {HI_MASK_V, LO_TOP};
   localparam logic [OUT_W-1:0] PRE_TERM   = {HI_MASK_V, LO_PRE};

   generate
      if (NIB_W < 2) begin : g_bad_w
         $error("cnt24_cascade: NIB_W must be at least 2");
      end
      if (LOW_INIT < 0 || LOW_INIT >= 2 ** (NIB_W - 1)) begin : g_bad_init
         $error("cnt24_cascade: LOW_INIT must lie below the low stage trigger value");
      end
      if (HIGH_MASK < 0 || HIGH_MASK >= 2 ** NIB_W || ((HIGH_MASK + 1) & HIGH_MASK) != 0) begin : g_bad_mask
         $error("cnt24_cascade: HIGH_MASK must be a run of low-order ones inside the stage");
      end
      if (MODULUS < 2) begin : g_bad_mod
         $error("cnt24_cascade: derived modulus too small");
      end
   endgenerate

   logic [NIB_W-1:0] lo;
   logic [NIB_W-1:0] hi;
   stage_op_e        lo_op;
   stage_op_e        hi_op;

   cnt24_ctrl #(
      .NIB_W     (NIB_W),
      .HIGH_MASK (HIGH_MASK)
   ) u_ctrl (
      .en    (cnt_en),
      .lo    (lo),
      .hi    (hi),
      .lo_op (lo_op),
      .hi_op (hi_op)
   );

   cnt24_stage #(
      .NIB_W    (NIB_W),
      .LOAD_VAL (LOW_INIT),
      .RST_VAL  (LOW_INIT)
   ) u_lo (
      .clk (clk),
      .rst (rst),
      .op  (lo_op),
      .q   (lo)
   );

   cnt24_stage #(
      .NIB_W    (NIB_W),
      .LOAD_VAL (0),
      .RST_VAL  (0)
   ) u_hi (
      .clk (clk),
      .rst (rst),
      .op  (hi_op),
      .q   (hi)
   );

   assign state = {hi, lo};

   cnt24_term #(
      .OUT_W      (OUT_W),
      .TERM_STATE (TERM_STATE),
      .PRE_TERM   (PRE_TERM),
      .REGISTERED (TERM_REG)
   ) u_term (
      .clk     (clk),
      .rst     (rst),
      .en      (cnt_en),
      .state   (state),
      .at_term (at_term)
   );

   AST_RESET_STATE: assert property (@(posedge clk)
      rst |=> (state == RST_STATE) && !at_term); // R1, R10

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      !cnt_en |=> $stable(state)); // R2

   AST_LOW_STEP: assert property (@(posedge clk) disable iff (rst)
      (cnt_en && !lo[TRIG]) |=> (lo == $past(lo) + ONE) && (hi == $past(hi))); // R3

   AST_LOW_RELOAD: assert property (@(posedge clk) disable iff (rst)
      (cnt_en && lo[TRIG]) |=> (lo == LO_INIT_V)); // R4

   AST_HIGH_CARRY: assert property (@(posedge clk) disable iff (rst)
      (cnt_en && lo[TRIG] && (state != TERM_STATE)) |=> (hi == $past(hi) + ONE)); // R5

   AST_WRAP_CLEAR: assert property (@(posedge clk) disable iff (rst)
      (cnt_en && (state == TERM_STATE)) |=> (state == RST_STATE)); // R6

   AST_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
      (lo >= LO_INIT_V) && (lo <= LO_TOP) && ((hi & ~HI_MASK_V) == '0)); // R9
endmodule

// File: tb/cnt24_cascade_test.sv
`timescale 1ns/1ps
module cnt24_cascade_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cnt_en = 1'b0;
   logic [7:0] state;
   logic       at_term;

   int compared = 0;
   int mismatched = 0;

   always #5 clk = ~clk;

   cnt24_cascade uut (
      .clk     (clk),
      .rst     (rst),
      .cnt_en  (cnt_en),
      .state   (state),
      .at_term (at_term)
   );

   // Reference: position in the 24-step cycle, state derived from it
   int idx = 0;
   int prv_idx = 0;
   bit prv_rst = 1'b1;
   bit prv_en = 1'b0;
   bit started = 1'b0;

   function automatic int model_state(int i);
      return ((i / 6) * 16) + 3 + (i % 6);
   endfunction

   always @(posedge clk) begin
      prv_idx <= idx;
      prv_rst <= rst;
      prv_en  <= cnt_en;
      started <= 1'b1;
      if (rst)         idx <= 0;
      else if (cnt_en) idx <= (idx + 1) % 24;
   end

   task automatic chk(string tag, int act, int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   // Per-cycle comparison, sampled at the falling edge
   always @(negedge clk) begin
      if (started) begin
         string tag;
         int lo_v;
         int hi_v;
         if (prv_rst && prv_en)       tag = "R10 reset over enable";
         else if (prv_rst)            tag = "R1 reset state";
         else if (!prv_en)            tag = "R2 hold while disabled";
         else if (prv_idx == 23)      tag = "R6 high clear at 38";
         else if (prv_idx % 6 == 5)   tag = "R4 R5 reload with carry";
         else                         tag = "R3 low increment";
         chk(tag, int'(state), model_state(idx));
         chk("R8 terminal flag", int'(at_term), (idx == 23) ? 1 : 0);
         if (!prv_rst) begin
            lo_v = int'(state[3:0]);
            hi_v = int'(state[7:4]);
            chk("R9 range", ((lo_v >= 3) && (lo_v <= 8) && (hi_v <= 3)) ? 1 : 0, 1);
         end
      end
   end

   task automatic step(bit r, bit e, int n);
      for (int k = 0; k < n; k++) begin
         rst = r;
         cnt_en = e;
         @(negedge clk);
      end
   endtask

   initial begin
      logic [255:0] seen;
      int distinct;
      @(negedge clk);
      step(1'b1, 1'b0, 3);
      // R7: full enabled lap from 0x03
      seen = '0;
      rst = 1'b0;
      cnt_en = 1'b1;
      for (int i = 0; i < 24; i++) begin
         seen[state] = 1'b1;
         @(negedge clk);
      end
      distinct = 0;
      for (int j = 0; j < 256; j++) distinct += seen[j] ? 1 : 0;
      chk("R7 distinct states", distinct, 24);
      chk("R7 returns to 03", int'(state), 8'h03);
      // R2: park with a reload pending (0x08), then with a clear pending (0x38)
      step(1'b0, 1'b1, 5);
      step(1'b0, 1'b0, 3);
      step(1'b0, 1'b1, 18);
      step(1'b0, 1'b0, 3);
      step(1'b0, 1'b1, 2);
      // Mixed enable pattern across several laps
      for (int i = 0; i < 300; i++) step(1'b0, ($urandom_range(0, 3) != 0), 1);
      // R10: reset while counting
      step(1'b1, 1'b1, 2);
      step(1'b0, 1'b1, 30);
      step(1'b1, 1'b0, 1);
      step(1'b0, 1'b1, 10);
      finish_run();
   end

   initial begin
      #(200000 * 10);
      mismatched++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end
endmodule